// File: doc/BRIEF.md
# Store Buffer with Byte Forwarding

The block holds the stores of one core between execution and a single-ported synchronous data cache. Stores enter in program order while still speculative, and a retire pulse later marks the oldest one as final. Final entries are written to the cache one at a time, oldest first. A misspeculation flush drops every entry that is still speculative. None of those entries ever reaches the cache.

Loads look into the buffer before they use the cache. Each byte lane takes its value from the youngest pending store that covers that byte, and the cache fills the lanes that no store covers. A fence request holds back loads until the stores that were buffered before it have been written. An atomic add first waits until the buffer is empty. It then reads the cache word, and in the next cycle writes the sum back and returns the value it read.

Top module: `store_buf`

## Requirements
- R1: After reset the block reports st_ready_o, ld_ready_o and rmw_ready_o high, cache_req_o low and ld_rvalid_o low.
- R2: Entries are written to the cache in allocation order, at most one per cycle, and only after they are retired. A write carries the entry's word address, its 32-bit data and its byte enables, where enable bit k covers bits 8k+7:8k.
- R3: A retire pulse marks the oldest valid entry that is not yet retired. A retire pulse with no such entry has no effect.
- R4: A flush removes every entry that is not retired, and these entries are never written or forwarded. When retire and flush arrive in the same cycle, the retire takes effect first. A store offered during a flush cycle is refused (st_ready_o low).
- R5: With 8 valid entries st_ready_o is low. It returns high once an entry leaves.
- R6: A load accepted in cycle t returns ld_rvalid_o and ld_rdata_o in cycle t+1. Each byte lane k comes from the youngest entry (retired or not) with the same word address and enable bit k set; the other lanes come from the cache. A store accepted in the same cycle as the load is not seen by that load.
- R7: When a load and a ready commit compete for the cache port, the load goes first and the commit follows in a later cycle.
- R8: A fence pulse drives ld_ready_o low in its own cycle. It stays low until every store accepted before the fence, and not flushed, has been written.
- R9: An atomic add is accepted only while rmw_ready_o is high. It waits until the buffer is empty, then issues a cache read. In the next cycle it writes old+operand with all four enables set, pulses rmw_done_o and shows the old value on rmw_old_o. No store is accepted while the add is in progress.
- R10: ld_ready_o is low from the cycle after an atomic add is accepted until that add completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | 32 | Store data |
| st_be_i | input | 4 | Store byte enables |
| st_ready_o | output | 1 | Store can be accepted |
| retire_i | input | 1 | Mark oldest speculative store retired |
| flush_i | input | 1 | Drop all speculative stores |
| fence_i | input | 1 | Full fence request |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | AW | Load word address |
| ld_ready_o | output | 1 | Load can be accepted |
| ld_rvalid_o | output | 1 | Load result valid |
| ld_rdata_o | output | 32 | Merged load data |
| rmw_valid_i | input | 1 | Atomic add request |
| rmw_addr_i | input | AW | Atomic add word address |
| rmw_opnd_i | input | 32 | Value to add |
| rmw_ready_o | output | 1 | Atomic add can be accepted |
| rmw_done_o | output | 1 | Atomic add completes this cycle |
| rmw_old_o | output | 32 | Value before the add |
| cache_req_o | output | 1 | Cache access |
| cache_we_o | output | 1 | Cache write (else read) |
| cache_addr_o | output | AW | Cache word address |
| cache_be_o | output | 4 | Cache write byte enables |
| cache_wdata_o | output | 32 | Cache write data |
| cache_rdata_i | input | 32 | Cache read data, one cycle after a read |

## Verification
The retire pulse and the flush pulse can arrive in the same cycle, and the two updates must then be applied in the right order. The bench buffers two speculative stores and raises both pulses together. It then checks that the cache write log holds only the older store. It also checks that a later load of the younger store's address returns the unmodified cache word. A second collision is a load and a ready commit that compete for the cache port. That case is judged cycle by cycle on the cache port: the read goes first and the write follows.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB = DW / 8;
  typedef logic [DW-1:0] word_t;
  typedef logic [NB-1:0] be_t;
  typedef enum logic [1:0] {RMW_IDLE, RMW_DRAIN, RMW_RD, RMW_WR} rmw_st_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue
  import sb_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         data_i,
  input  be_t           be_i,
  input  logic          retire_i,
  input  logic          flush_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output word_t         head_data_o,
  output be_t           head_be_o,
  output logic          has_ret_o,
  output logic [PW:0]   count_o,
  output logic [PW:0]   head_o,
  output logic [PW:0]   tail_o,
  output logic [PW:0]   rptr_nx_o,
  output logic [DEPTH-1:0] ent_vld_o,
  output logic [AW-1:0] ent_addr_o [DEPTH],
  output word_t         ent_data_o [DEPTH],
  output be_t           ent_be_o [DEPTH]
);
  logic [PW:0] head_q, tail_q, rptr_q, rptr_nx;
  logic [DEPTH-1:0] ret_v;
  logic ret_ok;
  logic [PW-1:0] head_idx;

  assign head_idx  = head_q[PW-1:0];
  assign ret_ok    = retire_i && (rptr_q != tail_q);
  assign rptr_nx   = rptr_q + (PW+1)'(ret_ok);
  assign rptr_nx_o = rptr_nx;
  assign count_o   = tail_q - head_q;
  assign head_o    = head_q;
  assign tail_o    = tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      rptr_q <= '0;
    end else begin
      head_q <= head_q + (PW+1)'(pop_i);
      rptr_q <= rptr_nx;
      tail_q <= flush_i ? rptr_nx : tail_q + (PW+1)'(alloc_i);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic vld_q, ret_q;
    logic [AW-1:0] addr_q;
    word_t data_q;
    be_t be_q;
    logic is_tail, is_head, is_rptr;
    assign is_tail = tail_q[PW-1:0] == PW'(i);
    assign is_head = head_idx == PW'(i);
    assign is_rptr = rptr_q[PW-1:0] == PW'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        ret_q <= 1'b0;
      end else if (alloc_i && is_tail) begin
        vld_q <= 1'b1;
        ret_q <= 1'b0;
      end else if (pop_i && is_head) begin
        vld_q <= 1'b0;
        ret_q <= 1'b0;
      end else if (ret_ok && is_rptr) begin
        ret_q <= 1'b1;
      end else if (flush_i && !ret_q) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_i && is_tail) begin
        addr_q <= addr_i;
        data_q <= data_i;
        be_q   <= be_i;
      end
    end

    assign ent_vld_o[i]  = vld_q;
    assign ret_v[i]      = ret_q;
    assign ent_addr_o[i] = addr_q;
    assign ent_data_o[i] = data_q;
    assign ent_be_o[i]   = be_q;
  end

  assign has_ret_o   = ent_vld_o[head_idx] && ret_v[head_idx];
  assign head_addr_o = ent_addr_o[head_idx];
  assign head_data_o = ent_data_o[head_idx];
  assign head_be_o   = ent_be_o[head_idx];

  p_pop_retired_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> has_ret_o);
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (count_o < (PW+1)'(DEPTH)));
  p_vld_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == (PW+1)'($countones(ent_vld_o)));
  p_flush_no_alloc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !alloc_i);
  p_flush_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (rptr_q == tail_q));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
  import sb_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [PW-1:0]    head_i,
  input  logic [DEPTH-1:0] ent_vld_i,
  input  logic [AW-1:0]    ent_addr_i [DEPTH],
  input  word_t            ent_data_i [DEPTH],
  input  be_t              ent_be_i [DEPTH],
  output be_t              hit_o,
  output word_t            data_o
);
  logic [DEPTH-1:0] amatch;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign amatch[i] = ent_vld_i[i] && (ent_addr_i[i] == ld_addr_i);
  end

  // scan oldest to youngest so the youngest hit wins per lane
  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic          lane_hit;
    logic [7:0]    lane_byte;
    logic [PW-1:0] idx;
    always_comb begin
      lane_hit  = 1'b0;
      lane_byte = '0;
      idx       = '0;
      for (int k = 0; k < DEPTH; k++) begin
        idx = head_i + k[PW-1:0];
        if (amatch[idx] && ent_be_i[idx][l]) begin
          lane_hit  = 1'b1;
          lane_byte = ent_data_i[idx][8*l +: 8];
        end
      end
    end
    assign hit_o[l]          = lane_hit;
    assign data_o[8*l +: 8]  = lane_byte;
  end
endmodule

// File: rtl/sb_fence.sv
module sb_fence #(
  parameter int unsigned PW = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fence_i,
  input  logic        flush_i,
  input  logic [PW:0] head_i,
  input  logic [PW:0] tail_i,
  input  logic [PW:0] rptr_nx_i,
  output logic        block_o
);
  logic        pend_q;
  logic [PW:0] tgt_q, dist_tgt, dist_keep;

  assign dist_tgt  = tgt_q - head_i;
  assign dist_keep = rptr_nx_i - head_i;
  assign block_o   = fence_i || (pend_q && (head_i != tgt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (fence_i) begin
      pend_q <= 1'b1;
      tgt_q  <= flush_i ? rptr_nx_i : tail_i;
    end else if (pend_q) begin
      if (head_i == tgt_q) pend_q <= 1'b0;
      else if (flush_i && (dist_tgt > dist_keep)) tgt_q <= rptr_nx_i; // flushed stores never commit
    end
  end

  p_tgt_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> ((tgt_q - head_i) <= (tail_i - head_i)));
endmodule

// File: rtl/store_buf.sv
module store_buf
  import sb_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [31:0]   st_data_i,
  input  logic [3:0]    st_be_i,
  output logic          st_ready_o,
  input  logic          retire_i,
  input  logic          flush_i,
  input  logic          fence_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_ready_o,
  output logic          ld_rvalid_o,
  output logic [31:0]   ld_rdata_o,
  input  logic          rmw_valid_i,
  input  logic [AW-1:0] rmw_addr_i,
  input  logic [31:0]   rmw_opnd_i,
  output logic          rmw_ready_o,
  output logic          rmw_done_o,
  output logic [31:0]   rmw_old_o,
  output logic          cache_req_o,
  output logic          cache_we_o,
  output logic [AW-1:0] cache_addr_o,
  output logic [3:0]    cache_be_o,
  output logic [31:0]   cache_wdata_o,
  input  logic [31:0]   cache_rdata_i
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [AW-1:0] head_addr;
  word_t         head_data;
  be_t           head_be;
  logic          has_ret, alloc, commit, ld_fire, fence_blk, rmw_busy, atomic, full;
  logic [PW:0]   count, head_ptr, tail_ptr, rptr_nx;
  logic [DEPTH-1:0] ent_vld;
  logic [AW-1:0] ent_addr [DEPTH];
  word_t         ent_data [DEPTH];
  be_t           ent_be [DEPTH];
  be_t           fwd_hit, fmask_q;
  word_t         fwd_data, fdata_q;
  logic          ld_pend_q;
  rmw_st_e       st_q;
  logic [AW-1:0] raddr_q;
  word_t         ropnd_q;

  assign full        = count == (PW+1)'(DEPTH);
  assign rmw_busy    = st_q != RMW_IDLE;
  assign atomic      = (st_q == RMW_RD) || (st_q == RMW_WR);
  assign st_ready_o  = !full && !rmw_busy && !flush_i;
  assign alloc       = st_valid_i && st_ready_o;
  assign ld_ready_o  = !fence_blk && !rmw_busy;
  assign ld_fire     = ld_valid_i && ld_ready_o;
  assign rmw_ready_o = !rmw_busy;
  assign commit      = has_ret && !atomic && !ld_fire;

  sb_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .addr_i(st_addr_i), .data_i(st_data_i), .be_i(st_be_i),
    .retire_i, .flush_i, .pop_i(commit),
    .head_addr_o(head_addr), .head_data_o(head_data), .head_be_o(head_be),
    .has_ret_o(has_ret), .count_o(count), .head_o(head_ptr), .tail_o(tail_ptr),
    .rptr_nx_o(rptr_nx), .ent_vld_o(ent_vld), .ent_addr_o(ent_addr),
    .ent_data_o(ent_data), .ent_be_o(ent_be)
  );

  sb_fwd #(.AW(AW), .DEPTH(DEPTH)) u_fwd (
    .ld_addr_i, .head_i(head_ptr[PW-1:0]), .ent_vld_i(ent_vld),
    .ent_addr_i(ent_addr), .ent_data_i(ent_data), .ent_be_i(ent_be),
    .hit_o(fwd_hit), .data_o(fwd_data)
  );

  sb_fence #(.PW(PW)) u_fence (
    .clk_i, .rst_ni, .fence_i, .flush_i,
    .head_i(head_ptr), .tail_i(tail_ptr), .rptr_nx_i(rptr_nx),
    .block_o(fence_blk)
  );

  // forwarding snapshot taken when the load is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      fmask_q   <= '0;
      fdata_q   <= '0;
    end else begin
      ld_pend_q <= ld_fire;
      if (ld_fire) begin
        fmask_q <= fwd_hit;
        fdata_q <= fwd_data;
      end
    end
  end

  assign ld_rvalid_o = ld_pend_q;
  for (genvar l = 0; l < NB; l++) begin : g_merge
    assign ld_rdata_o[8*l +: 8] = fmask_q[l] ? fdata_q[8*l +: 8] : cache_rdata_i[8*l +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RMW_IDLE;
      raddr_q <= '0;
      ropnd_q <= '0;
    end else begin
      unique case (st_q)
        RMW_IDLE: if (rmw_valid_i) begin
          st_q    <= RMW_DRAIN;
          raddr_q <= rmw_addr_i;
          ropnd_q <= rmw_opnd_i;
        end
        RMW_DRAIN: if (count == '0) st_q <= RMW_RD;
        RMW_RD:    st_q <= RMW_WR;
        RMW_WR:    st_q <= RMW_IDLE;
        default:   st_q <= RMW_IDLE;
      endcase
    end
  end

  assign rmw_done_o = st_q == RMW_WR;
  assign rmw_old_o  = rmw_done_o ? cache_rdata_i : '0;

  always_comb begin
    cache_req_o   = 1'b0;
    cache_we_o    = 1'b0;
    cache_addr_o  = '0;
    cache_be_o    = '0;
    cache_wdata_o = '0;
    if (st_q == RMW_RD) begin
      cache_req_o  = 1'b1;
      cache_addr_o = raddr_q;
    end else if (st_q == RMW_WR) begin
      cache_req_o   = 1'b1;
      cache_we_o    = 1'b1;
      cache_addr_o  = raddr_q;
      cache_be_o    = '1;
      cache_wdata_o = cache_rdata_i + ropnd_q;
    end else if (ld_fire) begin
      cache_req_o  = 1'b1;
      cache_addr_o = ld_addr_i;
    end else if (commit) begin
      cache_req_o   = 1'b1;
      cache_we_o    = 1'b1;
      cache_addr_o  = head_addr;
      cache_be_o    = head_be;
      cache_wdata_o = head_data;
    end
  end

  p_rmw_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RMW_RD) |-> (count == '0));
  p_rmw_b2b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RMW_RD) |=> (cache_req_o && cache_we_o && (cache_addr_o == $past(cache_addr_o))));
  p_ld_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire |=> ld_rvalid_o);
  p_no_store_in_rmw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_busy |-> !alloc);
endmodule

// File: tb/sim_store_buf.sv
module sim_store_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        st_valid = 0, retire = 0, flush = 0, fence = 0, ld_valid = 0, rmw_valid = 0;
  logic [9:0]  st_addr = '0, ld_addr = '0, rmw_addr = '0;
  logic [31:0] st_data = '0, rmw_opnd = '0;
  logic [3:0]  st_be = '0;
  logic        st_ready, ld_ready, ld_rvalid, rmw_ready, rmw_done;
  logic [31:0] ld_rdata, rmw_old;
  logic        cache_req, cache_we;
  logic [9:0]  cache_addr;
  logic [3:0]  cache_be;
  logic [31:0] cache_wdata, cache_rdata;

  store_buf u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_be_i(st_be),
    .st_ready_o(st_ready), .retire_i(retire), .flush_i(flush), .fence_i(fence),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_ready_o(ld_ready),
    .ld_rvalid_o(ld_rvalid), .ld_rdata_o(ld_rdata),
    .rmw_valid_i(rmw_valid), .rmw_addr_i(rmw_addr), .rmw_opnd_i(rmw_opnd),
    .rmw_ready_o(rmw_ready), .rmw_done_o(rmw_done), .rmw_old_o(rmw_old),
    .cache_req_o(cache_req), .cache_we_o(cache_we), .cache_addr_o(cache_addr),
    .cache_be_o(cache_be), .cache_wdata_o(cache_wdata), .cache_rdata_i(cache_rdata)
  );

  // cache model with write log
  logic [31:0] mem [1024];
  logic [9:0]  wl_addr [64];
  logic [31:0] wl_data [64];
  logic [3:0]  wl_be [64];
  int wn;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hC0DE_0000 + i;
      wn <= 0;
      cache_rdata <= '0;
    end else if (cache_req) begin
      if (cache_we) begin
        for (int b = 0; b < 4; b++)
          if (cache_be[b]) mem[cache_addr][8*b +: 8] <= cache_wdata[8*b +: 8];
        wl_addr[wn[5:0]] <= cache_addr;
        wl_data[wn[5:0]] <= cache_wdata;
        wl_be[wn[5:0]]   <= cache_be;
        wn <= wn + 1;
      end else begin
        cache_rdata <= mem[cache_addr];
      end
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic mid();
    @(negedge clk);
  endtask

  task automatic do_store(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    cyc();
    st_valid = 0;
  endtask

  task automatic do_retire();
    retire = 1;
    cyc();
    retire = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    cyc();
    flush = 0;
  endtask

  task automatic do_load(input logic [9:0] a, output logic [31:0] d);
    ld_valid = 1; ld_addr = a;
    cyc();
    ld_valid = 0;
    d = ld_rvalid ? ld_rdata : 32'hxxxx_xxxx;
  endtask

  typedef struct packed {
    logic [1:0]  op;   // 0 store, 1 retire, 2 load, 3 idle
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{2'd0, 10'h010, 32'h1122_3344, 4'hF, 32'h0},
    '{2'd2, 10'h010, 32'h0, 4'h0, 32'h1122_3344},
    '{2'd0, 10'h010, 32'hAABB_CCDD, 4'h2, 32'h0},
    '{2'd2, 10'h010, 32'h0, 4'h0, 32'h1122_CC44},
    '{2'd2, 10'h011, 32'h0, 4'h0, 32'hC0DE_0011},
    '{2'd0, 10'h011, 32'h9900_0000, 4'h8, 32'h0},
    '{2'd2, 10'h011, 32'h0, 4'h0, 32'h99DE_0011},
    '{2'd0, 10'h010, 32'h00EE_0000, 4'h4, 32'h0},
    '{2'd2, 10'h010, 32'h0, 4'h0, 32'h11EE_CC44},
    '{2'd1, 10'h000, 32'h0, 4'h0, 32'h0},
    '{2'd1, 10'h000, 32'h0, 4'h0, 32'h0},
    '{2'd1, 10'h000, 32'h0, 4'h0, 32'h0},
    '{2'd1, 10'h000, 32'h0, 4'h0, 32'h0},
    '{2'd3, 10'h000, 32'd10, 4'h0, 32'h0},
    '{2'd2, 10'h010, 32'h0, 4'h0, 32'h11EE_CC44},
    '{2'd2, 10'h011, 32'h0, 4'h0, 32'h99DE_0011},
    '{2'd2, 10'h012, 32'h0, 4'h0, 32'hC0DE_0012}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    mid();
    // R1 reset state
    chk("R1 st_ready", st_ready, 1);
    chk("R1 ld_ready", ld_ready, 1);
    chk("R1 rmw_ready", rmw_ready, 1);
    chk("R1 cache_req", cache_req, 0);
    chk("R1 ld_rvalid", ld_rvalid, 0);
    cyc();

    // table: R6 forwarding and merge, R2 drain
    for (int i = 0; i < 17; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        2'd0: do_store(v.addr, v.data, v.be);
        2'd1: do_retire();
        2'd2: begin do_load(v.addr, d); chk($sformatf("R6 vec%0d", i), d, v.exp); end
        default: repeat (v.data) cyc();
      endcase
    end
    chk("R2 write count", wn, 4);
    chk("R2 order data", wl_data[1], 32'hAABB_CCDD);
    chk("R2 order addr", {22'd0, wl_addr[2]}, 32'h11);
    chk("R2 order be", {28'd0, wl_be[3]}, 32'h4);

    // R2 no commit before retire
    base = wn;
    do_store(10'h20, 32'h1, 4'hF);
    do_store(10'h20, 32'h2, 4'hF);
    do_store(10'h21, 32'h3, 4'hF);
    repeat (4) cyc();
    chk("R2 held until retire", wn, base);
    repeat (3) do_retire();
    repeat (6) cyc();
    chk("R2 commits", wn, base + 3);
    chk("R2 first", wl_data[base], 32'h1);
    chk("R2 second", wl_data[base+1], 32'h2);
    chk("R2 third addr", {22'd0, wl_addr[base+2]}, 32'h21);
    chk("R2 mem", mem[10'h20], 32'h2);

    // R3 retire with nothing to retire is ignored; R4 flush drops
    base = wn;
    do_retire();
    do_store(10'h22, 32'h7, 4'hF);
    repeat (4) cyc();
    chk("R3 empty retire ignored", wn, base);
    flush = 1; st_valid = 1; st_addr = 10'h23; st_data = 32'h9; st_be = 4'hF;
    mid();
    chk("R4 store refused in flush", st_ready, 0);
    cyc();
    flush = 0; st_valid = 0;
    do_retire();
    repeat (4) cyc();
    chk("R4 flushed never written", wn, base);
    do_load(10'h22, d);
    chk("R4 flushed not forwarded", d, 32'hC0DE_0022);
    do_load(10'h23, d);
    chk("R4 refused store absent", d, 32'hC0DE_0023);

    // R4 retire and flush in same cycle
    base = wn;
    do_store(10'h30, 32'hA, 4'hF);
    do_store(10'h31, 32'hB, 4'hF);
    retire = 1; flush = 1;
    cyc();
    retire = 0; flush = 0;
    repeat (5) cyc();
    chk("R4 retire+flush count", wn, base + 1);
    chk("R4 retire+flush addr", {22'd0, wl_addr[base]}, 32'h30);
    do_load(10'h31, d);
    chk("R4 younger dropped", d, 32'hC0DE_0031);

    // R5 full
    base = wn;
    for (int i = 0; i < 8; i++) do_store(10'h80 + 10'(i), 32'(i), 4'hF);
    mid();
    chk("R5 full stalls", st_ready, 0);
    cyc();
    do_flush();
    mid();
    chk("R5 ready after flush", st_ready, 1);
    cyc();
    repeat (3) cyc();
    chk("R5 nothing written", wn, base);

    // R6 store and load in same cycle
    st_valid = 1; st_addr = 10'h50; st_data = 32'h1234_5678; st_be = 4'hF;
    ld_valid = 1; ld_addr = 10'h50;
    cyc();
    st_valid = 0; ld_valid = 0;
    chk("R6 same-cycle store unseen", ld_rdata, 32'hC0DE_0050);
    do_load(10'h50, d);
    chk("R6 next load forwards", d, 32'h1234_5678);
    do_flush();

    // R7 load wins port over ready commit
    do_store(10'h60, 32'h6060_6060, 4'hF);
    do_retire();
    ld_valid = 1; ld_addr = 10'h61;
    mid();
    chk("R7 load takes port", {cache_req, cache_we, cache_addr}, {2'b10, 10'h61});
    cyc();
    ld_valid = 0;
    chk("R7 load data", ld_rdata, 32'hC0DE_0061);
    mid();
    chk("R7 commit follows", {cache_req, cache_we, cache_addr}, {2'b11, 10'h60});
    cyc();

    // R8 fence
    repeat (2) cyc();
    do_store(10'h40, 32'h1, 4'hF);
    do_store(10'h41, 32'h2, 4'hF);
    base = wn;
    fence = 1;
    mid();
    chk("R8 fence cycle blocks", ld_ready, 0);
    cyc();
    fence = 0;
    repeat (2) cyc();
    chk("R8 still blocked", ld_ready, 0);
    do_retire();
    do_retire();
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      mid();
      if (ld_ready) begin
        seen = 1;
        chk("R8 stores done before release", wn, base + 2);
      end
      cyc();
    end
    chk("R8 released", seen, 1);

    // R9/R10 atomic add
    repeat (2) cyc();
    do_store(10'h70, 32'h5, 4'hF);
    rmw_valid = 1; rmw_addr = 10'h70; rmw_opnd = 32'h3;
    cyc();
    rmw_valid = 0;
    mid();
    chk("R9 busy", {rmw_ready, st_ready}, 2'b00);
    chk("R10 loads blocked", ld_ready, 0);
    cyc();
    mid();
    chk("R9 waits for drain", rmw_done, 0);
    cyc();
    do_retire();
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      mid();
      if (rmw_done) begin
        seen = 1;
        chk("R9 old value", rmw_old, 32'h5);
      end
      cyc();
    end
    chk("R9 completed", seen, 1);
    chk("R9 sum written", mem[10'h70], 32'h8);
    chk("R9 store before add", wl_data[wn-2], 32'h5);
    chk("R9 full write", {28'd0, wl_be[wn-1]}, 32'hF);
    mid();
    chk("R10 ready again", {rmw_ready, ld_ready, st_ready}, 3'b111);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule